// File: doc/BRIEF.md
# Two-Stage Free-Running Watchdog Timer

This block is a watchdog that runs from the low-speed clock. Its counter starts on its own when reset is released, and software cannot halt it. Software keeps it quiet by pulsing a clear input before the selected interval runs out.

When an interval expires with no clear, the block escalates in two steps. The first expiry raises a one-cycle non-maskable interrupt request and sets a sticky flag, then the counter starts timing a second interval. If that second interval also expires with no clear, the block raises a system reset request. The request stays high until the block itself is reset.

A 2-bit code selects one of four interval lengths. Each length is a power of two, and the lengths are spaced by factors of four. With the default base of 2^12 cycles at 32.768 kHz, the four intervals are 125 ms, 500 ms, 2 s and 8 s. A new code is adopted only when the counter restarts.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset is released the counter runs with no further input, and the first expiry occurs exactly one interval length of clock edges after the reset edge.
- R2: The interval length is 2^(BASE_SHIFT + 2*code) cycles: code 0 gives 2^B, code 1 gives 2^(B+2), code 2 gives 2^(B+4) and code 3 gives 2^(B+6). The default B is 12, which gives 4096, 16384, 65536 and 262144 cycles.
- R3: The first expiry drives `nmi_pulse` high for exactly one cycle and sets `warned`, which stays high until a clear or a reset.
- R4: A second expiry with no clear in between sets `reset_req` one interval length after the first expiry.
- R5: Once `reset_req` is set, it stays high through clears and further expiries, and only `rst` returns it to 0.
- R6: A clear strobe restarts the count from zero and drops `warned`. The next expiry then falls one interval length after the clear edge.
- R7: A clear sampled on the same edge as the terminal count takes priority, so no expiry is recorded on that edge.
- R8: A change of `period_sel` is adopted only at a reset, a clear or an expiry. A change made in the middle of an interval does not alter the interval already running.
- R9: While `rst` is high, `nmi_pulse`, `reset_req` and `warned` are all 0.
- R10: Once the reset request is raised, no further `nmi_pulse` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| period_sel | input | 2 | Interval length code |
| kick | input | 1 | Clear strobe from software, one cycle |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| reset_req | output | 1 | Sticky system reset request |
| warned | output | 1 | The first expiry has occurred |

## Verification
The assertions check, on every cycle, the following rules:
- the interrupt pulse lasts one cycle;
- the reset request is sticky;
- the interrupt never appears without the flag, or after the reset request;
- a clear always zeroes the count and suppresses an expiry;
- the latched interval code holds between restarts;
- the count never passes the terminal value.

Only the bench scenarios can show the exact edge on which each expiry lands for every code. They also show that a code change in mid-interval takes effect one interval later, and that a clear on the terminal edge postpones the interrupt by a full interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [1:0] {
        WD_ARMED   = 2'd0,
        WD_WARNED  = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_stage_e;

    // Events produced by the counter each cycle
    typedef struct packed {
        logic expire;   // terminal count reached with no clear
        logic reload;   // counter restarts (clear or expiry)
    } tick_evt_t;

    // Shift amount of the interval length: base + 2*code
    function automatic int unsigned period_shift(input logic [SEL_W-1:0] code,
                                                 input int unsigned base);
        return base + (32'(code) << 1);
    endfunction

endpackage

// File: rtl/wdt_period_hold.sv
module wdt_period_hold
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             reload,
    output logic [SEL_W-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst || reload)
            sel_q <= sel_in;
    end

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(sel_q));

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel_q,
    output tick_evt_t        evt
);

    localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
    localparam int unsigned CW      = BASE_SHIFT + 2 * MAX_SEL;
    localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

    logic [CW-1:0] count;
    logic [CW-1:0] term;

    always_comb begin
        term       = ~(ALL_ONES << period_shift(sel_q, BASE_SHIFT));
        evt.expire = (count == term) && !kick;
        evt.reload = kick || evt.expire;
    end

    always_ff @(posedge clk) begin
        if (rst || evt.reload)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    // R6
    kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (count == '0));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= term);

endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      kick,
    input  tick_evt_t evt,
    output logic      nmi_pulse,
    output logic      reset_req,
    output logic      warned
);

    wd_stage_e stage_q;
    logic      nmi_q;
    logic      rreq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= WD_ARMED;
            nmi_q   <= 1'b0;
            rreq_q  <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            unique case (stage_q)
                WD_ARMED: begin
                    if (evt.expire) begin
                        stage_q <= WD_WARNED;
                        nmi_q   <= 1'b1;
                    end
                end
                WD_WARNED: begin
                    if (kick) begin
                        stage_q <= WD_ARMED;
                    end else if (evt.expire) begin
                        stage_q <= WD_TRIPPED;
                        rreq_q  <= 1'b1;
                    end
                end
                default: begin
                    stage_q <= WD_TRIPPED;
                end
            endcase
        end
    end

    assign nmi_pulse = nmi_q;
    assign reset_req = rreq_q;
    assign warned    = (stage_q != WD_ARMED);

    // R3
    nmi_single_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |=> !nmi_pulse);

    // R3
    nmi_flag_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |-> warned);

    // R5
    rst_req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req);

    // R10
    no_nmi_after_trip_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> !nmi_pulse);

    // R7
    kick_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (kick && !reset_req) |=> !nmi_pulse);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] period_sel,
    input  logic       kick,
    output logic       nmi_pulse,
    output logic       reset_req,
    output logic       warned
);

    logic [SEL_W-1:0] sel_q;
    tick_evt_t        evt;

    wdt_period_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .sel_in (period_sel),
        .reload (evt.reload),
        .sel_q  (sel_q)
    );

    wdt_tick_counter #(.BASE_SHIFT(BASE_SHIFT)) u_count (
        .clk   (clk),
        .rst   (rst),
        .kick  (kick),
        .sel_q (sel_q),
        .evt   (evt)
    );

    wdt_escalator u_esc (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .evt       (evt),
        .nmi_pulse (nmi_pulse),
        .reset_req (reset_req),
        .warned    (warned)
    );

endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 3;

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] len;
    } vec_t;

    // R2: code -> interval length with B = 3
    localparam vec_t VEC [4] = '{
        '{2'd0, 16'd8}, '{2'd1, 16'd32}, '{2'd2, 16'd128}, '{2'd3, 16'd512}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] period_sel = 2'd0;
    logic       kick = 1'b0;
    logic       nmi_pulse, reset_req, warned;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_two_stage #(.BASE_SHIFT(BASE)) i_wdog_two_stage (
        .clk(clk), .rst(rst), .period_sel(period_sel), .kick(kick),
        .nmi_pulse(nmi_pulse), .reset_req(reset_req), .warned(warned)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst = 1'b1; period_sel = s; kick = 1'b0;
        tick(1);
        rst = 1'b0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        tick(1);
        kick = 1'b0;
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_up();
        end
    end

    initial begin
        int nmi_seen;
        @(negedge clk);
        tick(2);
        // R9: reset state
        chk("R9", "nmi in reset", nmi_pulse, 0);
        chk("R9", "reset_req in reset", reset_req, 0);
        chk("R9", "warned in reset", warned, 0);

        // Table: R1 R2 R3 R4 per interval code
        foreach (VEC[i]) begin
            do_reset(VEC[i].sel);
            tick(VEC[i].len - 1);
            chk("R1", "nmi before first expiry", nmi_pulse, 0);
            tick(1);
            chk("R2", "nmi at first expiry", nmi_pulse, 1);
            chk("R3", "warned at first expiry", warned, 1);
            tick(1);
            chk("R3", "nmi one cycle only", nmi_pulse, 0);
            tick(VEC[i].len - 2);
            chk("R4", "reset_req before second expiry", reset_req, 0);
            tick(1);
            chk("R4", "reset_req at second expiry", reset_req, 1);
        end

        // R6: periodic clears keep the watchdog quiet
        do_reset(2'd0);
        for (int k = 0; k < 5; k++) begin
            tick(6);
            pulse_kick();
            chk("R6", "warned under periodic clear", warned, 0);
        end
        tick(7);
        chk("R6", "nmi before interval after clear", nmi_pulse, 0);
        tick(1);
        chk("R6", "nmi one interval after clear", nmi_pulse, 1);
        // R6: a clear while warned drops the flag and restarts stage one
        pulse_kick();
        chk("R6", "warned after clear", warned, 0);
        tick(7);
        chk("R6", "nmi early after warned clear", nmi_pulse, 0);
        tick(1);
        chk("R6", "nmi again after warned clear", nmi_pulse, 1);
        chk("R6", "no reset_req after warned clear", reset_req, 0);

        // R7: clear on the terminal edge wins
        do_reset(2'd0);
        tick(7);
        pulse_kick();
        chk("R7", "nmi with clear at terminal", nmi_pulse, 0);
        chk("R7", "warned with clear at terminal", warned, 0);
        tick(7);
        chk("R7", "nmi early after terminal clear", nmi_pulse, 0);
        tick(1);
        chk("R7", "nmi one interval after terminal clear", nmi_pulse, 1);

        // R8: select change mid-interval applies only after the next expiry
        do_reset(2'd0);
        period_sel = 2'd1;
        tick(7);
        chk("R8", "nmi before old interval end", nmi_pulse, 0);
        tick(1);
        chk("R8", "nmi at old interval end", nmi_pulse, 1);
        tick(31);
        chk("R8", "reset_req before new interval end", reset_req, 0);
        tick(1);
        chk("R8", "reset_req at new interval end", reset_req, 1);

        // R5 / R10: sticky reset request, no further interrupts
        pulse_kick();
        chk("R5", "reset_req after clear", reset_req, 1);
        chk("R5", "warned stays after trip", warned, 1);
        nmi_seen = 0;
        for (int k = 0; k < 80; k++) begin
            tick(1);
            if (nmi_pulse) nmi_seen++;
        end
        chk("R10", "nmi pulses after trip", nmi_seen, 0);
        chk("R5", "reset_req held", reset_req, 1);
        do_reset(2'd0);
        chk("R5", "reset_req cleared by rst", reset_req, 0);
        chk("R5", "warned cleared by rst", warned, 0);

        done = 1'b1;
        finish_up();
    end

endmodule